// File: doc/BRIEF.md
# Selectable Line Test Pattern Generator

This block is the transmit half of a bit error rate tester for T1-style lines. On every clock where the bit enable is high it shifts out one test bit. A three-bit mode input chooses the pattern. The patterns are two maximal-length pseudorandom sequences (511 and 63 bits), a quasi-random source whose zero runs are capped, and a set of fixed repeating words with known ones densities. One shared shift register serves every pseudorandom mode. A single phase counter serves every fixed word.

A mode change restarts the chosen pattern from a known seed or phase, so a receiver set to the same mode can lock on. An error-inject strobe inverts exactly one outgoing bit. A checker can use it to confirm that the far end counts errors. The strobe does not disturb the pattern state, so the stream stays aligned after the inverted bit. Line coding, framing and the analog interface are handled elsewhere.

Top module: `linepat_gen`

## Requirements
- R1: While reset (active low) is asserted, and after release until the first enabled edge, bit_out is 0. The mode codes are: 0 = 511-bit pseudorandom, 1 = 63-bit pseudorandom, 2 = quasi-random, 3 = alternating, 4 = all ones, 5 = one-in-eight, 6 = three-in-24, 7 = all zeros.
- R2: Mode 0 emits nine ones first, then b[n] = b[n-9] xor b[n-5]. The sequence repeats every 511 bits and holds 256 ones per period.
- R3: Mode 1 emits six ones first, then b[n] = b[n-6] xor b[n-5]. The sequence repeats every 63 bits and holds 32 ones per period.
- R4: Mode 2 runs a raw sequence r whose first 20 bits are ones, with r[n] = r[n-20] xor r[n-17] after that. The emitted bit is r[n]. The exception is when the previous 14 emitted (uninverted) bits were all zero: then the emitted bit is 1.
- R5: In mode 2 the output never carries more than 14 consecutive zeros.
- R6: Mode 3 emits 1,0,1,0,…, starting with 1.
- R7: Mode 4 emits only ones. Mode 7 emits only zeros.
- R8: Mode 5 emits a single 1 followed by seven 0s, with a period of 8 bits.
- R9: Mode 6 repeats a 24-bit word whose ones sit at positions 1, 5 and 22. Position 0 is the first bit after a restart.
- R10: On an edge where bit_en is high, bit_out takes the next pattern bit. On an edge where bit_en is low, bit_out and the pattern position both hold.
- R11: An edge at which mode differs from the mode in use restarts the pattern and leaves bit_out unchanged, even if bit_en is high. The next enabled bit is bit 0 of the new pattern. An injection pending at that edge, or arriving on it, is discarded.
- R12: err_inject on an enabled edge inverts the bit emitted there. err_inject on an idle edge inverts the next enabled bit. Any number of strobes before one enabled bit invert only that bit. Later bits follow the pattern as if no strobe had occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Advance the pattern by one bit on this edge |
| mode | input | 3 | Pattern select (codes in R1) |
| err_inject | input | 1 | Invert one outgoing bit |
| bit_out | output | 1 | Registered serial test bit |

## Verification
Every pattern bit is due at the very rising edge that samples bit_en high, so it is visible one register stage later. A mode change consumes its own edge and produces no new bit, and the first bit of the new pattern appears on the next enabled edge. The bench drives inputs on the falling edge and reads bit_out 2 ns after the rising edge. For every enabled edge it compares bit_out against a bench-side model advanced once per enabled edge. For idle and restart edges it compares against the value before that edge.

// File: rtl/linepat_pkg.sv
package linepat_pkg;

   typedef enum logic [2:0] {
      PAT_PN_LONG  = 3'd0,
      PAT_PN_SHORT = 3'd1,
      PAT_QUASI    = 3'd2,
      PAT_ALT      = 3'd3,
      PAT_MARK     = 3'd4,
      PAT_ONE8     = 3'd5,
      PAT_DENS24   = 3'd6,
      PAT_SPACE    = 3'd7
   } pat_mode_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/linepat_lfsr.sv
module linepat_lfsr
   import linepat_pkg::*;
#(
   parameter int LONG_LEN  = 9,
   parameter int LONG_TAP  = 5,
   parameter int SHORT_LEN = 6,
   parameter int SHORT_TAP = 5,
   parameter int QUASI_LEN = 20,
   parameter int QUASI_TAP = 17
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      reseed,
   input  logic      advance,
   input  pat_mode_e mode,
   output logic      pn_bit
);

   localparam int SR_W  = max3(LONG_LEN, SHORT_LEN, QUASI_LEN);
   localparam int IDX_W = $clog2(SR_W);

   localparam logic [IDX_W-1:0] LONG_OI  = IDX_W'(LONG_LEN - 1);
   localparam logic [IDX_W-1:0] LONG_TI  = IDX_W'(LONG_TAP - 1);
   localparam logic [IDX_W-1:0] SHORT_OI = IDX_W'(SHORT_LEN - 1);
   localparam logic [IDX_W-1:0] SHORT_TI = IDX_W'(SHORT_TAP - 1);
   localparam logic [IDX_W-1:0] QUASI_OI = IDX_W'(QUASI_LEN - 1);
   localparam logic [IDX_W-1:0] QUASI_TI = IDX_W'(QUASI_TAP - 1);

   if (LONG_TAP < 1 || LONG_TAP >= LONG_LEN) begin : g_bad_long
      $error("linepat_lfsr: LONG_TAP must lie below LONG_LEN");
   end
   if (SHORT_TAP < 1 || SHORT_TAP >= SHORT_LEN) begin : g_bad_short
      $error("linepat_lfsr: SHORT_TAP must lie below SHORT_LEN");
   end
   if (QUASI_TAP < 1 || QUASI_TAP >= QUASI_LEN) begin : g_bad_quasi
      $error("linepat_lfsr: QUASI_TAP must lie below QUASI_LEN");
   end
   if (SR_W < 2) begin : g_bad_width
      $error("linepat_lfsr: register too short");
   end

   logic [SR_W-1:0]  sr;
   logic [IDX_W-1:0] out_idx;
   logic [IDX_W-1:0] tap_idx;
   logic             fb;

   always_comb begin
      unique case (mode)
         PAT_PN_SHORT: begin
            out_idx = SHORT_OI;
            tap_idx = SHORT_TI;
         end
         PAT_QUASI: begin
            out_idx = QUASI_OI;
            tap_idx = QUASI_TI;
         end
         default: begin
            out_idx = LONG_OI;
            tap_idx = LONG_TI;
         end
      endcase
   end

   assign pn_bit = sr[out_idx];
   assign fb     = sr[out_idx] ^ sr[tap_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '1;
      end else if (reseed) begin
         sr <= '1;
      end else if (advance) begin
         sr <= {sr[SR_W-2:0], fb};
      end
   end

   // R2
   lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|sr));

endmodule

// File: rtl/linepat_word.sv
module linepat_word
   import linepat_pkg::*;
#(
   parameter int                  WORD_LEN  = 24,
   parameter logic [WORD_LEN-1:0] DENS_MASK = 24'h40_0022
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      reseed,
   input  logic      advance,
   input  pat_mode_e mode,
   output logic      word_bit
);

   localparam int               PH_W = $clog2(WORD_LEN);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(WORD_LEN - 1);

   if (WORD_LEN < 8 || (WORD_LEN % 8) != 0) begin : g_bad_len
      $error("linepat_word: WORD_LEN must be a multiple of 8");
   end

   logic [PH_W-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (reseed) begin
         ph <= '0;
      end else if (advance) begin
         ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      end
   end

   always_comb begin
      unique case (mode)
         PAT_ALT:    word_bit = ~ph[0];
         PAT_MARK:   word_bit = 1'b1;
         PAT_ONE8:   word_bit = (ph[2:0] == 3'd0);
         PAT_DENS24: word_bit = DENS_MASK[ph];
         default:    word_bit = 1'b0;
      endcase
   end

   // R9
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph <= PH_LAST));

endmodule

// File: rtl/linepat_limit.sv
module linepat_limit #(
   parameter int RUN_MAX = 14,
   parameter bit ENABLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reseed,
   input  logic advance,
   input  logic raw_bit,
   output logic lim_bit
);

   if (RUN_MAX < 1) begin : g_bad_run
      $error("linepat_limit: RUN_MAX must be positive");
   end

   if (ENABLE) begin : g_cap
      localparam int              CNT_W = $clog2(RUN_MAX + 1);
      localparam logic [CNT_W-1:0] CAP  = CNT_W'(RUN_MAX);

      logic [CNT_W-1:0] zrun;

      assign lim_bit = (zrun >= CAP) ? 1'b1 : raw_bit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            zrun <= '0;
         end else if (reseed) begin
            zrun <= '0;
         end else if (advance) begin
            zrun <= lim_bit ? '0 : zrun + 1'b1;
         end
      end

      // R5
      zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (zrun <= CAP));
   end else begin : g_pass
      assign lim_bit = raw_bit;
   end

endmodule

// File: rtl/linepat_gen.sv
module linepat_gen
   import linepat_pkg::*;
#(
   parameter int                  LONG_LEN  = 9,
   parameter int                  LONG_TAP  = 5,
   parameter int                  SHORT_LEN = 6,
   parameter int                  SHORT_TAP = 5,
   parameter int                  QUASI_LEN = 20,
   parameter int                  QUASI_TAP = 17,
   parameter int                  QUASI_RUN = 14,
   parameter bit                  QUASI_CAP = 1'b1,
   parameter int                  WORD_LEN  = 24,
   parameter logic [WORD_LEN-1:0] DENS_MASK = 24'h40_0022
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic [2:0] mode,
   input  logic       err_inject,
   output logic       bit_out
);

   pat_mode_e mode_in;
   pat_mode_e mode_q;
   logic      restart;
   logic      advance;
   logic      pending;
   logic      flip;
   logic      pn_bit;
   logic      lim_bit;
   logic      word_bit;
   logic      gen_bit;

   assign mode_in = pat_mode_e'(mode);
   assign restart = (mode_in != mode_q);
   assign advance = bit_en & ~restart;
   assign flip    = advance & (pending | err_inject);

   linepat_lfsr #(
      .LONG_LEN  (LONG_LEN),
      .LONG_TAP  (LONG_TAP),
      .SHORT_LEN (SHORT_LEN),
      .SHORT_TAP (SHORT_TAP),
      .QUASI_LEN (QUASI_LEN),
      .QUASI_TAP (QUASI_TAP)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .reseed  (restart),
      .advance (advance),
      .mode    (mode_q),
      .pn_bit  (pn_bit)
   );

   linepat_limit #(
      .RUN_MAX (QUASI_RUN),
      .ENABLE  (QUASI_CAP)
   ) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .reseed  (restart),
      .advance (advance),
      .raw_bit (pn_bit),
      .lim_bit (lim_bit)
   );

   linepat_word #(
      .WORD_LEN  (WORD_LEN),
      .DENS_MASK (DENS_MASK)
   ) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .reseed   (restart),
      .advance  (advance),
      .mode     (mode_q),
      .word_bit (word_bit)
   );

   always_comb begin
      unique case (mode_q)
         PAT_PN_LONG, PAT_PN_SHORT: gen_bit = pn_bit;
         PAT_QUASI:                 gen_bit = lim_bit;
         default:                   gen_bit = word_bit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= PAT_PN_LONG;
         pending <= 1'b0;
         bit_out <= 1'b0;
      end else begin
         mode_q <= mode_in;
         if (restart || advance) begin
            pending <= 1'b0;
         end else if (err_inject) begin
            pending <= 1'b1;
         end
         if (advance) begin
            bit_out <= gen_bit ^ flip;
         end
      end
   end

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(bit_out));

   // R11
   restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_in != mode_q) |=> $stable(bit_out));

   // R12
   inject_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && err_inject && (mode_in == mode_q)) |=> (bit_out != $past(gen_bit)));

endmodule

// File: tb/linepat_gen_test.sv
`timescale 1ns/1ps
module linepat_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [2:0] mode = 3'd0;
   logic       err_inject = 1'b0;
   logic       bit_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   linepat_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .mode       (mode),
      .err_inject (err_inject),
      .bit_out    (bit_out)
   );

   typedef struct packed {
      logic [2:0] md;
      logic [9:0] per;
      logic [9:0] ones;
      logic       first;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 10'd511, 10'd256, 1'b1},
      '{3'd1, 10'd63,  10'd32,  1'b1},
      '{3'd3, 10'd2,   10'd1,   1'b1},
      '{3'd4, 10'd1,   10'd1,   1'b1},
      '{3'd5, 10'd8,   10'd1,   1'b1},
      '{3'd6, 10'd24,  10'd3,   1'b0},
      '{3'd7, 10'd1,   10'd0,   1'b0},
      '{3'd2, 10'd20,  10'd20,  1'b1}
   };

   // bench-side pattern model
   int          m_n;
   logic [19:0] m_h;
   int          m_z;
   logic [2:0]  m_mode;

   task automatic m_restart(input logic [2:0] md);
      m_mode = md;
      m_n    = 0;
      m_h    = '0;
      m_z    = 0;
   endtask

   task automatic m_next(output logic b);
      logic raw;
      int   pos;
      pos = m_n % 24;
      case (m_mode)
         3'd0: begin raw = (m_n < 9)  ? 1'b1 : (m_h[8] ^ m_h[4]);   b = raw; end
         3'd1: begin raw = (m_n < 6)  ? 1'b1 : (m_h[5] ^ m_h[4]);   b = raw; end
         3'd2: begin
            raw = (m_n < 20) ? 1'b1 : (m_h[19] ^ m_h[16]);
            b   = (m_z >= 14) ? 1'b1 : raw;
            m_z = b ? 0 : m_z + 1;
         end
         3'd3: begin b = (m_n % 2 == 0); raw = b; end
         3'd4: begin b = 1'b1; raw = b; end
         3'd5: begin b = (m_n % 8 == 0); raw = b; end
         3'd6: begin b = (pos == 1 || pos == 5 || pos == 22); raw = b; end
         default: begin b = 1'b0; raw = b; end
      endcase
      m_h = {m_h[18:0], raw};
      m_n++;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic en, input logic inj);
      @(negedge clk);
      bit_en     = en;
      err_inject = inj;
      @(posedge clk);
      #2;
   endtask

   task automatic set_mode(input logic [2:0] md, input logic en, input logic inj);
      @(negedge clk);
      mode       = md;
      bit_en     = en;
      err_inject = inj;
      @(posedge clk);
      #2;
      m_restart(md);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   logic bits [0:1023];

   initial begin
      logic exp_b;
      logic prev;
      int   mism;
      int   first_bad;
      int   zr;
      int   zmax;

      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      chk(bit_out == 1'b0, "R1 in reset", bit_out, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) step(1'b0, 1'b0);
      chk(bit_out == 1'b0, "R1 idle after reset", bit_out, 0);

      // table walk: each row restarts a mode and runs two periods
      for (int r = 0; r < 8; r++) begin
         int per;
         int ones;
         int pmis;
         per = int'(VECS[r].per);
         set_mode(VECS[r].md, 1'b0, 1'b0);
         mism = 0;
         first_bad = -1;
         for (int i = 0; i < 2 * per; i++) begin
            step(1'b1, 1'b0);
            bits[i] = bit_out;
            m_next(exp_b);
            if (bit_out !== exp_b) begin
               mism++;
               if (first_bad < 0) first_bad = i;
            end
         end
         ones = 0;
         pmis = 0;
         for (int i = 0; i < per; i++) begin
            if (bits[i]) ones++;
            if (bits[i] !== bits[i + per]) pmis++;
         end
         // R2 R3 R4 R6 R7 R8 R9 per mode
         chk(bits[0] == VECS[r].first, $sformatf("R2/R3/R4/R6/R7/R8/R9 first bit mode %0d", VECS[r].md),
             bits[0], VECS[r].first);
         chk(ones == int'(VECS[r].ones), $sformatf("R2/R3/R6/R7/R8/R9 ones count mode %0d", VECS[r].md),
             ones, VECS[r].ones);
         if (VECS[r].md != 3'd2)
            chk(pmis == 0, $sformatf("R2/R3/R6/R7/R8/R9 period repeat mode %0d", VECS[r].md), pmis, 0);
         chk(mism == 0, $sformatf("R10 model stream mode %0d first_bad_bit=%0d", VECS[r].md, first_bad),
             mism, 0);
      end

      // R10: idle edges hold output and position
      set_mode(3'd1, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) begin
         step(1'b1, 1'b0);
         m_next(exp_b);
         chk(bit_out == exp_b, "R3 short sequence before idle", bit_out, exp_b);
      end
      prev = bit_out;
      for (int i = 0; i < 4; i++) begin
         step(1'b0, 1'b0);
         chk(bit_out == prev, "R10 hold while idle", bit_out, prev);
      end
      mism = 0;
      for (int i = 0; i < 12; i++) begin
         step(1'b1, 1'b0);
         m_next(exp_b);
         if (bit_out !== exp_b) mism++;
      end
      chk(mism == 0, "R10 sequence resumes after idle", mism, 0);

      // R12: injection on an enabled edge
      set_mode(3'd3, 1'b0, 1'b0);
      step(1'b1, 1'b1);
      m_next(exp_b);
      chk(bit_out == !exp_b, "R12 same-edge inversion", bit_out, !exp_b);
      mism = 0;
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 1'b0);
         m_next(exp_b);
         if (bit_out !== exp_b) mism++;
      end
      chk(mism == 0, "R12 stream aligned after inversion", mism, 0);

      // R12: two idle strobes -> one inverted bit
      prev = bit_out;
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      chk(bit_out == prev, "R12 idle strobe leaves output", bit_out, prev);
      step(1'b1, 1'b0);
      m_next(exp_b);
      chk(bit_out == !exp_b, "R12 pending inversion", bit_out, !exp_b);
      step(1'b1, 1'b0);
      m_next(exp_b);
      chk(bit_out == exp_b, "R12 only one bit inverted", bit_out, exp_b);

      // R11: strobe pending across a restart is dropped
      step(1'b0, 1'b1);
      prev = bit_out;
      set_mode(3'd4, 1'b1, 1'b1);
      chk(bit_out == prev, "R11 restart edge holds output", bit_out, prev);
      step(1'b1, 1'b0);
      m_next(exp_b);
      chk(bit_out == exp_b, "R11 pending strobe discarded", bit_out, exp_b);

      // R11: mode change with bit_en high mid-stream, then R9 word positions
      set_mode(3'd5, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
      prev = bit_out;
      set_mode(3'd6, 1'b1, 1'b0);
      chk(bit_out == prev, "R11 hold with bit_en high", bit_out, prev);
      mism = 0;
      for (int i = 0; i < 48; i++) begin
         step(1'b1, 1'b0);
         exp_b = ((i % 24) == 1 || (i % 24) == 5 || (i % 24) == 22);
         if (bit_out !== exp_b) mism++;
      end
      chk(mism == 0, "R9 ones at positions 1 5 22", mism, 0);

      // R7: all-zeros mode stays low over many bits
      set_mode(3'd7, 1'b0, 1'b0);
      mism = 0;
      for (int i = 0; i < 30; i++) begin
         step(1'b1, 1'b0);
         if (bit_out !== 1'b0) mism++;
      end
      chk(mism == 0, "R7 space mode", mism, 0);

      // R4 R5: long quasi-random run
      set_mode(3'd2, 1'b0, 1'b0);
      mism = 0;
      first_bad = -1;
      zr = 0;
      zmax = 0;
      for (int i = 0; i < 120000; i++) begin
         step(1'b1, 1'b0);
         m_next(exp_b);
         if (bit_out !== exp_b) begin
            mism++;
            if (first_bad < 0) first_bad = i;
         end
         if (bit_out) zr = 0;
         else begin
            zr++;
            if (zr > zmax) zmax = zr;
         end
      end
      chk(mism == 0, $sformatf("R4 quasi stream first_bad_bit=%0d", first_bad), mism, 0);
      chk(zmax <= 14, "R5 longest zero run", zmax, 14);

      step(1'b0, 1'b0);
      finish_run();
   end

endmodule